// File: doc/BRIEF.md
# Configuration Access Router with Bridge Bus Numbering

This block takes configuration requests from a host-side port and steers each one to a function on the root bus or on a secondary bus behind a bridge. A request carries a 24-bit address, a byte length and write data. The address holds three fields: the target bus in bits 23:16, the device/function slot in bits 15:8 and the register offset in bits 7:0. The router finds the bus, checks that a function sits in the slot, and forwards the access to that function. On a read it returns the function's data, cut to the access length. A read that finds no target returns all-ones of that length. A write that finds no target is dropped.

The population is fixed by parameters. Root functions fill slots upward from a minimum device/function number in steps of 8, which is the first-free-slot rule applied to an empty bus. The lowest-indexed root functions are bridges. Each bridge owns one secondary bus, and that bus's functions take slots 0, 8, 16 and so on. The router owns each bridge's identity bytes and its secondary bus number field. A secondary bus is unnumbered until software writes that field. From then on the bus answers to the programmed number. A later write renumbers it at once.

Top module: `cfgr_router`

## Requirements
- R1: The bus number is taken from address bits 23:16, the device/function slot from bits 15:8 and the register offset from bits 7:0. The offset, length and write data reach the function unchanged on `fwd_offset`, `fwd_len` and `fwd_wdata`.
- R2: Root function k (k below N_ROOT) sits at slot DEVFN_MIN+8k on bus ROOT_BUS. A request to it raises `fwd_valid` in the request cycle with `fwd_func` = k, provided k is N_BRIDGE or more.
- R3: After reset every secondary bus is unnumbered. A request to any bus other than ROOT_BUS finds no target until a bridge has been programmed.
- R4: Root functions 0 to N_BRIDGE-1 are bridges, and writes to them are never forwarded. A write to a bridge at offset 0x19 loads write-data bits 7:0 as the secondary bus number. A write of length 2 or more at offset 0x18 loads write-data bits 15:8 instead. Function j of bridge b's bus sits at slot 8j and has `fwd_func` = N_ROOT + b*N_SEC + j.
- R5: A read that finds no target returns 0xFF for length 1, 0xFFFF for length 2, and 0xFFFFFFFF for length 4 or any other length code.
- R6: A write that finds no target does not raise `fwd_valid` and changes no bridge bus number.
- R7: A bridge's reads come from a little-endian register image. Bytes 0x0A/0x0B hold class 0x0604, byte 0x0E holds header type 0x81, and byte 0x19 holds the secondary bus number, which is 0 while unnumbered. All other bytes are 0. A read returns the image shifted right by 8 × offset[1:0] and cut to the length.
- R8: Every request gets `rsp_valid` exactly one cycle later, and only then. For a write, `rsp_rdata` is 0.
- R9: Read data from a forwarded function (the `fn_rdata` slice of that function, right-justified) is masked to the access length.
- R10: If bus numbers collide, the root bus wins over any secondary. Among secondaries, the lowest bridge index wins.
- R11: A new secondary bus number takes effect from the very next request, and the old number stops matching.
- R12: Reset (synchronous, active high) clears `rsp_valid` and `rsp_rdata` and leaves all secondaries unnumbered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus, device/function slot, register offset |
| req_len | input | 3 | Access length in bytes (1, 2, 4) |
| req_wdata | input | 32 | Write data, right-justified |
| fn_rdata | input | NF*32 | Read data of each function, function i in slice i |
| fwd_valid | output | 1 | Access forwarded to a function this cycle |
| fwd_write | output | 1 | Direction of the forwarded access |
| fwd_func | output | FW | Index of the target function |
| fwd_offset | output | 8 | Register offset |
| fwd_len | output | 3 | Access length |
| fwd_wdata | output | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data sized to the length |

## Verification
The bench builds the router with three root functions, two of them bridges, two functions per secondary bus, and the lowest root slot moved up to 16. This puts absent slots below the minimum, between valid root slots and above the last secondary slot, and it makes bridge indices differ from function indices. With two bridges the bench can give both bridges the same number, and can give one bridge the root's number, so both collision priorities are exercised. It can also renumber a bridge while the other bridge keeps its number. Random traffic mixes every length code with writes to the two bus-number offsets, so renumbering happens in the middle of a stream.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  localparam logic [7:0]  OFS_SECBUS_BYTE = 8'h19;
  localparam logic [7:0]  OFS_SECBUS_WORD = 8'h18;
  localparam logic [31:0] IMG_CLASS_DW    = 32'h0604_0000;
  localparam logic [31:0] IMG_HEADER_DW   = 32'h0081_0000;

  function automatic logic [31:0] len_mask(input logic [2:0] len);
    case (len)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode #(
  parameter int N_ROOT    = 4,
  parameter int N_BRIDGE  = 2,
  parameter int N_SEC     = 3,
  parameter int DEVFN_MIN = 8,
  parameter int ROOT_BUS  = 0,
  parameter int FW        = 4,
  parameter int BW        = 1
) (
  input  logic [15:0]   bus_devfn,
  input  logic          sec_vld [N_BRIDGE],
  input  logic [7:0]    sec_num [N_BRIDGE],
  output logic          hit,
  output logic          to_bridge,
  output logic [FW-1:0] func,
  output logic [BW-1:0] bridge_idx
);

  logic [7:0]    bus;
  logic [7:0]    devfn;
  logic [8:0]    rel;
  logic          on_root;
  logic          sec_hit;
  logic [BW-1:0] sec_sel;
  logic          root_slot_ok;
  logic          sec_slot_ok;

  assign bus   = bus_devfn[15:8];
  assign devfn = bus_devfn[7:0];

  always_comb begin
    on_root = (bus == 8'(ROOT_BUS));
    sec_hit = 1'b0;
    sec_sel = '0;
    // descending scan: the lowest matching bridge is taken last and wins
    for (int b = N_BRIDGE - 1; b >= 0; b--) begin
      if (sec_vld[b] && sec_num[b] == bus) begin
        sec_hit = 1'b1;
        sec_sel = BW'(b);
      end
    end
    rel          = {1'b0, devfn} - 9'(DEVFN_MIN);
    root_slot_ok = !rel[8] && (rel[2:0] == 3'd0) && (int'(rel[7:3]) < N_ROOT);
    sec_slot_ok  = (devfn[2:0] == 3'd0) && (int'(devfn[7:3]) < N_SEC);

    hit        = 1'b0;
    to_bridge  = 1'b0;
    func       = '0;
    bridge_idx = '0;
    if (on_root) begin
      hit        = root_slot_ok;
      func       = FW'(rel[7:3]);
      to_bridge  = root_slot_ok && (int'(rel[7:3]) < N_BRIDGE);
      bridge_idx = BW'(rel[7:3]);
    end else if (sec_hit) begin
      hit  = sec_slot_ok;
      func = FW'(N_ROOT + int'(sec_sel) * N_SEC + int'(devfn[7:3]));
    end
  end

endmodule

// File: rtl/cfgr_bridge_regs.sv
module cfgr_bridge_regs
  import cfgr_pkg::*;
#(
  parameter int N_BRIDGE = 2,
  parameter int BW       = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_bridge,
  input  logic [7:0]    wr_offset,
  input  logic [2:0]    wr_len,
  input  logic [15:0]   wr_data,
  input  logic [BW-1:0] rd_bridge,
  input  logic [5:0]    rd_dw,
  output logic [31:0]   rd_dword,
  output logic          sec_vld [N_BRIDGE],
  output logic [7:0]    sec_num [N_BRIDGE]
);

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
    always_ff @(posedge clk) begin
      if (rst) begin
        sec_vld[b] <= 1'b0;
        sec_num[b] <= 8'h00;
      end else if (wr_en && wr_bridge == BW'(b)) begin
        if (wr_offset == OFS_SECBUS_BYTE) begin
          sec_vld[b] <= 1'b1;
          sec_num[b] <= wr_data[7:0];
        end else if (wr_offset == OFS_SECBUS_WORD && wr_len >= 3'd2) begin
          sec_vld[b] <= 1'b1;
          sec_num[b] <= wr_data[15:8];
        end
      end
    end
  end

  always_comb begin
    case (rd_dw)
      6'h02:   rd_dword = IMG_CLASS_DW;
      6'h03:   rd_dword = IMG_HEADER_DW;
      6'h06:   rd_dword = {16'h0000, sec_num[rd_bridge], 8'h00};
      default: rd_dword = 32'h0;
    endcase
  end

endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
  import cfgr_pkg::*;
#(
  parameter int N_ROOT    = 4,
  parameter int N_BRIDGE  = 2,
  parameter int N_SEC     = 3,
  parameter int DEVFN_MIN = 8,
  parameter int ROOT_BUS  = 0,
  localparam int NF       = N_ROOT + N_BRIDGE * N_SEC,
  localparam int FW       = (NF > 1) ? $clog2(NF) : 1,
  localparam int BW       = (N_BRIDGE > 1) ? $clog2(N_BRIDGE) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [23:0]     req_addr,
  input  logic [2:0]      req_len,
  input  logic [31:0]     req_wdata,
  input  logic [NF*32-1:0] fn_rdata,
  output logic            fwd_valid,
  output logic            fwd_write,
  output logic [FW-1:0]   fwd_func,
  output logic [7:0]      fwd_offset,
  output logic [2:0]      fwd_len,
  output logic [31:0]     fwd_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata
);

  logic          hit;
  logic          to_bridge;
  logic [FW-1:0] func;
  logic [BW-1:0] bridge_idx;
  logic          sec_vld [N_BRIDGE];
  logic [7:0]    sec_num [N_BRIDGE];
  logic [31:0]   br_dword;
  logic [31:0]   fn_word;
  logic [31:0]   rd_value;
  logic          br_wr;

  cfgr_decode #(
    .N_ROOT(N_ROOT), .N_BRIDGE(N_BRIDGE), .N_SEC(N_SEC),
    .DEVFN_MIN(DEVFN_MIN), .ROOT_BUS(ROOT_BUS), .FW(FW), .BW(BW)
  ) u_decode (
    .bus_devfn (req_addr[23:8]),
    .sec_vld   (sec_vld),
    .sec_num   (sec_num),
    .hit       (hit),
    .to_bridge (to_bridge),
    .func      (func),
    .bridge_idx(bridge_idx)
  );

  assign br_wr = req_valid && req_write && hit && to_bridge;

  cfgr_bridge_regs #(.N_BRIDGE(N_BRIDGE), .BW(BW)) u_bridges (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (br_wr),
    .wr_bridge(bridge_idx),
    .wr_offset(req_addr[7:0]),
    .wr_len   (req_len),
    .wr_data  (req_wdata[15:0]),
    .rd_bridge(bridge_idx),
    .rd_dw    (req_addr[7:2]),
    .rd_dword (br_dword),
    .sec_vld  (sec_vld),
    .sec_num  (sec_num)
  );

  // forwarding strobe in the request cycle
  assign fwd_valid  = req_valid && hit && !to_bridge;
  assign fwd_write  = req_write;
  assign fwd_func   = func;
  assign fwd_offset = req_addr[7:0];
  assign fwd_len    = req_len;
  assign fwd_wdata  = req_wdata;

  always_comb begin
    fn_word = 32'h0;
    for (int i = 0; i < NF; i++) begin
      if (func == FW'(i)) fn_word = fn_rdata[i*32 +: 32];
    end
  end

  always_comb begin
    if (!hit)
      rd_value = len_mask(req_len);
    else if (to_bridge)
      rd_value = (br_dword >> {req_addr[1:0], 3'b000}) & len_mask(req_len);
    else
      rd_value = fn_word & len_mask(req_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_rdata <= req_write ? 32'h0 : rd_value;
    end
  end

endmodule

// File: rtl/cfgr_router_chk.sv
module cfgr_router_chk #(
  parameter int N_ROOT   = 4,
  parameter int N_BRIDGE = 2,
  parameter int N_SEC    = 3,
  localparam int NF      = N_ROOT + N_BRIDGE * N_SEC,
  localparam int FW      = (NF > 1) ? $clog2(NF) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [2:0]    req_len,
  input logic          fwd_valid,
  input logic [FW-1:0] fwd_func,
  input logic          rsp_valid,
  input logic [31:0]   rsp_rdata
);

  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_rsp_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_wr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));

  p_byte_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_len == 3'd1) |=> (rsp_rdata[31:8] == 24'h0));

  p_half_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_len == 3'd2) |=> (rsp_rdata[31:16] == 16'h0));

  p_fwd_gated_r2: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> req_valid);

  p_fwd_nobridge_r4: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (int'(fwd_func) >= N_BRIDGE && int'(fwd_func) < NF));

endmodule

bind cfgr_router cfgr_router_chk #(
  .N_ROOT(N_ROOT), .N_BRIDGE(N_BRIDGE), .N_SEC(N_SEC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_len  (req_len),
  .fwd_valid(fwd_valid),
  .fwd_func (fwd_func),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata)
);

// File: tb/cfgr_router_bench.sv
module cfgr_router_bench;

  localparam int NR   = 3;
  localparam int NB   = 2;
  localparam int NS   = 2;
  localparam int DMIN = 16;
  localparam int RB   = 0;
  localparam int NF   = NR + NB * NS;
  localparam int FW   = (NF > 1) ? $clog2(NF) : 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [23:0]     req_addr = '0;
  logic [2:0]      req_len = 3'd4;
  logic [31:0]     req_wdata = '0;
  logic [NF*32-1:0] fn_rdata;
  logic            fwd_valid, fwd_write;
  logic [FW-1:0]   fwd_func;
  logic [7:0]      fwd_offset;
  logic [2:0]      fwd_len;
  logic [31:0]     fwd_wdata;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit         mvld [NB];
  logic [7:0] mnum [NB];

  always #2 clk = ~clk;

  cfgr_router #(
    .N_ROOT(NR), .N_BRIDGE(NB), .N_SEC(NS), .DEVFN_MIN(DMIN), .ROOT_BUS(RB)
  ) u_cfgr_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .fn_rdata(fn_rdata), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
    .fwd_func(fwd_func), .fwd_offset(fwd_offset), .fwd_len(fwd_len),
    .fwd_wdata(fwd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] pat(int i);
    return 32'hA1B2_C3D4 ^ (32'(i) * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] lmask(logic [2:0] len);
    if (len == 3'd1) return 32'hFF;
    if (len == 3'd2) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  // expected target: hit, bridge flag, function index, bridge index
  task automatic route(input logic [23:0] a, output bit hit, output bit tob,
                       output int fi, output int bi);
    int bus = int'(a[23:16]);
    int dv  = int'(a[15:8]);
    int sb  = -1;
    hit = 0; tob = 0; fi = 0; bi = 0;
    for (int b = 0; b < NB; b++)
      if (sb < 0 && mvld[b] && int'(mnum[b]) == bus) sb = b;
    if (bus == RB) begin
      for (int k = 0; k < NR; k++)
        if (dv == DMIN + 8 * k) begin
          hit = 1; fi = k; tob = (k < NB); bi = k;
        end
    end else if (sb >= 0) begin
      for (int j = 0; j < NS; j++)
        if (dv == 8 * j) begin
          hit = 1; fi = NR + sb * NS + j;
        end
    end
  endtask

  function automatic logic [31:0] img(int b, logic [7:0] ofs);
    logic [31:0] dw;
    case (ofs[7:2])
      6'h02:   dw = 32'h0604_0000;
      6'h03:   dw = 32'h0081_0000;
      6'h06:   dw = {16'h0, (mvld[b] ? mnum[b] : 8'h00), 8'h00};
      default: dw = 32'h0;
    endcase
    return dw >> (8 * int'(ofs[1:0]));
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [7:0] bus, input logic [7:0] dv,
                        input logic [7:0] ofs, input logic [2:0] len,
                        input logic [31:0] wd, input string tag);
    bit hit, tob;
    int fi, bi;
    logic [31:0] exp;
    logic [23:0] a = {bus, dv, ofs};
    route(a, hit, tob, fi, bi);
    if (wr) exp = 32'h0;
    else if (!hit) exp = lmask(len);
    else if (tob) exp = img(bi, ofs) & lmask(len);
    else exp = pat(fi) & lmask(len);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_len = len; req_wdata = wd;
    #1;
    chk(fwd_valid == (hit && !tob), {tag, " fwd_valid"}, 32'(fwd_valid), 32'(hit && !tob));
    if (hit && !tob) begin
      chk(int'(fwd_func) == fi, {tag, " fwd_func"}, 32'(fwd_func), 32'(fi));
      chk(fwd_offset == ofs && fwd_len == len && fwd_wdata == wd && fwd_write == wr,
          {tag, " R1 forwarded fields"}, {fwd_offset, 13'h0, fwd_len, 8'h0}, {ofs, 13'h0, len, 8'h0});
    end
    @(posedge clk);
    #1;
    chk(rsp_valid == 1'b1, {tag, " R8 rsp_valid"}, 32'(rsp_valid), 32'h1);
    chk(rsp_rdata == exp, {tag, " rsp_rdata"}, rsp_rdata, exp);
    req_valid = 0;
    if (wr && hit && tob) begin
      if (ofs == 8'h19) begin mvld[bi] = 1; mnum[bi] = wd[7:0]; end
      else if (ofs == 8'h18 && len >= 3'd2) begin mvld[bi] = 1; mnum[bi] = wd[15:8]; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] lens [4] = '{3'd1, 3'd2, 3'd4, 3'd3};
    void'($urandom(32'd20240611));
    for (int i = 0; i < NF; i++) fn_rdata[i*32 +: 32] = pat(i);
    for (int b = 0; b < NB; b++) begin mvld[b] = 0; mnum[b] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 0, "R12 rsp_valid after reset", 32'(rsp_valid), 0);
    chk(rsp_rdata == 0, "R12 rsp_rdata after reset", rsp_rdata, 0);
    chk(fwd_valid == 0, "R12 fwd_valid idle", 32'(fwd_valid), 0);
    @(posedge clk); #1;
    chk(rsp_valid == 0, "R8 no request no response", 32'(rsp_valid), 0);

    // R3 unnumbered secondaries; R5 all-ones sizing
    do_req(0, 8'd1, 8'd0, 8'h00, 3'd4, 0, "R3 R5 len4");
    do_req(0, 8'd0, 8'd0, 8'h00, 3'd2, 0, "R3 R5 len2");
    do_req(0, 8'd0, 8'd8, 8'h04, 3'd1, 0, "R5 below DEVFN_MIN len1");
    do_req(0, 8'd0, 8'd17, 8'h04, 3'd3, 0, "R5 odd slot len3");
    // R2 root functions, R9 masking
    do_req(0, 8'd0, 8'd32, 8'h40, 3'd4, 0, "R2 R1 root func");
    do_req(0, 8'd0, 8'd32, 8'h41, 3'd1, 0, "R9 byte mask");
    do_req(1, 8'd0, 8'd32, 8'h20, 3'd4, 32'hDEAD_BEEF, "R8 R2 write fwd");
    // R7 bridge image
    do_req(0, 8'd0, 8'd16, 8'h0A, 3'd2, 0, "R7 class");
    do_req(0, 8'd0, 8'd16, 8'h0E, 3'd1, 0, "R7 header");
    do_req(0, 8'd0, 8'd24, 8'h08, 3'd4, 0, "R7 class dword");
    do_req(0, 8'd0, 8'd24, 8'h19, 3'd1, 0, "R7 unnumbered byte");
    // R4 programming
    do_req(1, 8'd0, 8'd16, 8'h19, 3'd1, 32'h05, "R4 byte program");
    do_req(0, 8'd5, 8'd8, 8'h00, 3'd4, 0, "R4 sec func");
    do_req(0, 8'd0, 8'd16, 8'h19, 3'd1, 0, "R7 R4 readback");
    do_req(1, 8'd0, 8'd24, 8'h18, 3'd2, 32'h0900, "R4 word program");
    do_req(0, 8'd9, 8'd0, 8'h10, 3'd2, 0, "R4 second bridge bus");
    do_req(0, 8'd5, 8'd16, 8'h00, 3'd2, 0, "R5 absent sec slot");
    // R6 writes to absent targets
    do_req(1, 8'h40, 8'd16, 8'h19, 3'd1, 32'h77, "R6 absent bus write");
    do_req(1, 8'd0, 8'd20, 8'h19, 3'd1, 32'h66, "R6 absent slot write");
    do_req(0, 8'd0, 8'd16, 8'h19, 3'd1, 0, "R6 bus number kept");
    do_req(0, 8'd5, 8'd0, 8'h00, 3'd4, 0, "R6 route kept");
    // R10 priority, R11 renumbering
    do_req(1, 8'd0, 8'd24, 8'h19, 3'd1, 32'h05, "R10 collide secondaries");
    do_req(0, 8'd5, 8'd0, 8'h00, 3'd4, 0, "R10 lowest bridge wins");
    do_req(1, 8'd0, 8'd16, 8'h18, 3'd4, 32'h0000_0000, "R10 bridge to root number");
    do_req(0, 8'd0, 8'd32, 8'h00, 3'd4, 0, "R10 root wins");
    do_req(0, 8'd5, 8'd8, 8'h00, 3'd4, 0, "R11 other bridge now owns bus");
    do_req(1, 8'd0, 8'd16, 8'h19, 3'd1, 32'h21, "R11 renumber");
    do_req(0, 8'd0, 8'd0, 8'h00, 3'd1, 0, "R11 old number gone");
    do_req(0, 8'h21, 8'd8, 8'h00, 3'd4, 0, "R11 new number live");

    // random traffic
    for (int n = 0; n < 500; n++) begin
      logic [7:0] bus, dv, ofs;
      logic [2:0] len;
      bit wr;
      int r = $urandom % 4;
      bus = (r == 0) ? 8'(RB) : (r == 1) ? mnum[0] : (r == 2) ? mnum[1] : 8'($urandom);
      dv  = ($urandom % 2 == 0) ? 8'((($urandom % 2) ? DMIN : 0) + 8 * ($urandom % 4))
                                : 8'($urandom);
      wr  = ($urandom % 10) < 3;
      ofs = 8'($urandom);
      if (wr && ($urandom % 3 == 0)) ofs = ($urandom % 2) ? 8'h19 : 8'h18;
      len = lens[$urandom % 4];
      do_req(wr, bus, dv, ofs, len, $urandom, "R2 R4 R5 R9 R10 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule